// File: doc/BRIEF.md
# Prioritized Interrupt Entry Controller

This block sits beside a small 16-bit processor core and decides, at the end of each instruction, whether the core must take an interrupt instead of fetching the next opcode. Four sources feed it: a non-maskable host request, a timer request, a DMA-finished request and a maskable host request. The non-maskable source always wins and masks itself once taken. The three maskable sources are ranked in a fixed order, are gated by the processor's I flag and by their own enable bits, and all share one vector.

Once a source is accepted, the block runs the entry sequence one bus cycle at a time. It first makes a dummy read at the current PC and spends one idle cycle. It then pushes the return address and the status byte through a valid/ready byte bus, decrementing the stack pointer after each push. Finally it hands the core a new PC, a new status byte and a new stack pointer. The core supplies a strobe on the last cycle of every instruction, plus a hold input that freezes all acceptance while the core sleeps or sits in reset.

Each source has a status flag and an acknowledge bit. Software writes the whole acknowledge register at once. A 1 drops that source's status flag on the next clock and blocks the source. A 0 releases the source again.

FSM states: `ST_IDLE` (waiting; the only state in which a request is evaluated), `ST_FETCH` (dummy read at PC), `ST_SPIN` (idle cycle), `ST_PUSH_BANK`, `ST_PUSH_HI`, `ST_PUSH_LO`, `ST_PUSH_FLAGS` (the four stack writes), and `ST_VECTOR` (one-cycle load of the new core state).

Transitions:
- `ST_IDLE`→`ST_FETCH` on acceptance.
- `ST_FETCH`→`ST_SPIN` when the read is granted.
- `ST_SPIN`→`ST_PUSH_BANK` in native mode, and `ST_SPIN`→`ST_PUSH_HI` in emulation mode.
- Each push state advances to the next one (`ST_PUSH_BANK`→`ST_PUSH_HI`→`ST_PUSH_LO`→`ST_PUSH_FLAGS`→`ST_VECTOR`) when its write is granted.
- `ST_VECTOR`→`ST_IDLE` unconditionally.

Top module: `intr_entry_ctrl`

## Requirements
- R1: A request is evaluated only in a cycle where `last_cycle` is 1, `hold` is 0 and `pending` is 0. Outside such cycles `pending` never rises.
- R2: The non-maskable source is checked first and ignores `i_flag`. It is accepted when `nmi_req` is 1 and acknowledge bit 0 is 0.
- R3: Accepting the non-maskable source sets `sel_vec` to `nmi_vec`, sets `stat[0]` and sets `ack_bits[0]`. While `ack_bits[0]` stays 1 the source is not accepted again.
- R4: Maskable sources are considered only when `i_flag` is 0, in the order timer (bit 1), DMA (bit 2), host (bit 3). Each needs its enable bit (`irq_en[0]`, `irq_en[1]` and `irq_en[2]` respectively) at 1 and its acknowledge bit at 0.
- R5: An accepted maskable source sets `sel_vec` to `irq_vec` and sets only its own `stat` bit.
- R6: `wake` pulses for exactly the first cycle after an acceptance, which cancels any wait-for-interrupt state in the core.
- R7: In native mode (`emu_mode`=0) the bus sequence is as follows. First a read at `pc_in`. Then writes of bank, PC[15:8], PC[7:0] and status, to addresses `sp_in`, `sp_in`-1, `sp_in`-2 and `sp_in`-3, each written as {8'h00, SP}.
- R8: In emulation mode the bank push is skipped, giving three writes starting at `sp_in`. Status bit 4 is forced to 0 in the pushed byte.
- R9: In the final cycle `entry_done` is 1 with `new_pc` = {8'h00, `sel_vec`}. `new_p` equals the captured status with bit 2 (I) set and bit 3 (D) cleared. `new_sp` equals `sp_in` minus the number of pushes.
- R10: While `hold` is 1 no request is accepted.
- R11: After reset, `pending`, `wake`, `stat`, `ack_bits`, `sel_vec` and `bus_valid` are all 0.
- R12: When `ack_we` is 1, `ack_bits` takes `ack_val` on the next clock, and each `stat` bit whose `ack_val` bit is 1 drops to 0.
- R13: While `bus_valid` is 1 and `bus_ready` is 0, the bus address and data stay unchanged and the sequence does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| last_cycle | input | 1 | Core is in the last cycle of an instruction |
| hold | input | 1 | Core held in sleep or reset |
| i_flag | input | 1 | Processor interrupt-disable flag |
| emu_mode | input | 1 | Core in emulation mode |
| nmi_req | input | 1 | Non-maskable host request |
| tmr_req | input | 1 | Timer request |
| dma_req | input | 1 | DMA-finished request |
| host_req | input | 1 | Maskable host request |
| irq_en | input | 3 | Enables: timer, DMA, host |
| ack_we | input | 1 | Write strobe for the acknowledge register |
| ack_val | input | 4 | Acknowledge register write data |
| nmi_vec | input | 16 | Non-maskable vector |
| irq_vec | input | 16 | Shared maskable vector |
| pc_in | input | 24 | Core PC (bank and offset) |
| p_in | input | 8 | Core status byte |
| sp_in | input | 16 | Core stack pointer |
| bus_ready | input | 1 | Bus grants the current access |
| pending | output | 1 | Entry sequence in progress |
| wake | output | 1 | One-cycle wait-cancel pulse |
| sel_vec | output | 16 | Vector of the last accepted source |
| stat | output | 4 | Per-source status flags |
| ack_bits | output | 4 | Acknowledge register |
| bus_valid | output | 1 | Bus access requested |
| bus_write | output | 1 | 1 for a push, 0 for the dummy read |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 8 | Push data |
| entry_done | output | 1 | New core state is valid this cycle |
| new_pc | output | 24 | PC to load |
| new_p | output | 8 | Status to load |
| new_sp | output | 16 | Stack pointer to load |

## Verification
The bench attacks the priority ladder with every source requested at once. It toggles the I flag, and it leaves the non-maskable request high after it has been taken. A design that forgot the self-masking would take the same source twice, and one that let I mask it would skip it. Emulation-mode entries catch a design that still pushes the bank or leaves status bit 4 set. Random `bus_ready` stalls catch a sequence that advances or changes its address without a grant. Acknowledge writes issued between entries catch flags that fail to drop, or sources that stay blocked after their bit is released.

// File: rtl/intr_pkg.sv
package intr_pkg;
    localparam int NSRC     = 4;
    localparam int SRC_NMI  = 0;
    localparam int SRC_TMR  = 1;
    localparam int SRC_DMA  = 2;
    localparam int SRC_HOST = 3;

    localparam int PBIT_I = 2;
    localparam int PBIT_D = 3;
    localparam int PBIT_B = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SPIN,
        ST_PUSH_BANK,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_FLAGS,
        ST_VECTOR
    } entry_state_t;
endpackage

// File: rtl/intr_pick.sv
module intr_pick
    import intr_pkg::*;
(
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-2:0] en,
    input  logic [NSRC-1:0] blocked,
    input  logic            i_flag,
    output logic [NSRC-1:0] grant,
    output logic            any
);
    logic [NSRC-1:0] elig;

    // Source 0 ignores the I flag; the others need enable and I clear.
    always_comb begin
        elig[SRC_NMI] = req[SRC_NMI] & ~blocked[SRC_NMI];
        for (int i = 1; i < NSRC; i++) begin
            elig[i] = req[i] & en[i-1] & ~blocked[i] & ~i_flag;
        end
    end

    // Lowest index wins.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
        any = found;
    end
endmodule

// File: rtl/intr_status.sv
module intr_status
    import intr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [NSRC-1:0] grant,
    input  logic            ack_we,
    input  logic [NSRC-1:0] ack_val,
    output logic [NSRC-1:0] ack_q,
    output logic [NSRC-1:0] stat_q
);
    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_src
            logic set_now;
            logic ack_one;

            assign set_now = take & grant[g];
            assign ack_one = ack_we & ack_val[g];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stat_q[g] <= 1'b0;
                end else begin
                    stat_q[g] <= (stat_q[g] & ~ack_one) | set_now;
                end
            end

            if (g == SRC_NMI) begin : g_self_mask
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        ack_q[g] <= 1'b0;
                    end else begin
                        ack_q[g] <= (ack_we ? ack_val[g] : ack_q[g]) | set_now;
                    end
                end
            end else begin : g_plain
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        ack_q[g] <= 1'b0;
                    end else if (ack_we) begin
                        ack_q[g] <= ack_val[g];
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/intr_entry_fsm.sv
module intr_entry_fsm
    import intr_pkg::*;
#(
    parameter int AW = 24,
    parameter int VW = 16,
    parameter int SW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [VW-1:0] vec_in,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] p_in,
    input  logic [SW-1:0] sp_in,
    input  logic          emu_in,
    input  logic          bus_ready,
    output logic          busy,
    output logic [VW-1:0] vec_q,
    output logic          bus_valid,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          done,
    output logic [AW-1:0] new_pc,
    output logic [DW-1:0] new_p,
    output logic [SW-1:0] new_sp
);
    localparam int BW = AW - VW;
    localparam logic [SW-1:0] SP_ONE = 1;
    localparam logic [DW-1:0] B_MASK = DW'(1) << PBIT_B;
    localparam logic [DW-1:0] I_MASK = DW'(1) << PBIT_I;
    localparam logic [DW-1:0] D_MASK = DW'(1) << PBIT_D;

    entry_state_t  state_q, state_d;
    logic [AW-1:0] pc_q;
    logic [DW-1:0] p_q;
    logic [SW-1:0] sp_q;
    logic          emu_q;
    logic          push_fire;

    assign push_fire = bus_valid & bus_ready & bus_write;

    // State register and captured context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            p_q     <= '0;
            sp_q    <= '0;
            emu_q   <= 1'b0;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                pc_q  <= pc_in;
                p_q   <= p_in;
                sp_q  <= sp_in;
                emu_q <= emu_in;
                vec_q <= vec_in;
            end else if (push_fire) begin
                sp_q <= sp_q - SP_ONE;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (take) state_d = ST_FETCH;
            ST_FETCH:      if (bus_ready) state_d = ST_SPIN;
            ST_SPIN:       state_d = emu_q ? ST_PUSH_HI : ST_PUSH_BANK;
            ST_PUSH_BANK:  if (bus_ready) state_d = ST_PUSH_HI;
            ST_PUSH_HI:    if (bus_ready) state_d = ST_PUSH_LO;
            ST_PUSH_LO:    if (bus_ready) state_d = ST_PUSH_FLAGS;
            ST_PUSH_FLAGS: if (bus_ready) state_d = ST_VECTOR;
            ST_VECTOR:     state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        busy      = (state_q != ST_IDLE);
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        done      = 1'b0;
        new_pc    = {{BW{1'b0}}, vec_q};
        new_p     = (p_q | I_MASK) & ~D_MASK;
        new_sp    = sp_q;
        unique case (state_q)
            ST_IDLE, ST_SPIN: ;
            ST_FETCH: begin
                bus_valid = 1'b1;
                bus_addr  = pc_q;
            end
            ST_PUSH_BANK: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = {{(AW-SW){1'b0}}, sp_q};
                bus_wdata = pc_q[AW-1 -: DW];
            end
            ST_PUSH_HI: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = {{(AW-SW){1'b0}}, sp_q};
                bus_wdata = pc_q[VW-1 -: DW];
            end
            ST_PUSH_LO: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = {{(AW-SW){1'b0}}, sp_q};
                bus_wdata = pc_q[DW-1:0];
            end
            ST_PUSH_FLAGS: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = {{(AW-SW){1'b0}}, sp_q};
                bus_wdata = emu_q ? (p_q & ~B_MASK) : p_q;
            end
            ST_VECTOR: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/intr_entry_ctrl.sv
module intr_entry_ctrl
    import intr_pkg::*;
#(
    parameter int AW = 24,
    parameter int VW = 16,
    parameter int SW = 16,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            last_cycle,
    input  logic            hold,
    input  logic            i_flag,
    input  logic            emu_mode,
    input  logic            nmi_req,
    input  logic            tmr_req,
    input  logic            dma_req,
    input  logic            host_req,
    input  logic [NSRC-2:0] irq_en,
    input  logic            ack_we,
    input  logic [NSRC-1:0] ack_val,
    input  logic [VW-1:0]   nmi_vec,
    input  logic [VW-1:0]   irq_vec,
    input  logic [AW-1:0]   pc_in,
    input  logic [DW-1:0]   p_in,
    input  logic [SW-1:0]   sp_in,
    input  logic            bus_ready,
    output logic            pending,
    output logic            wake,
    output logic [VW-1:0]   sel_vec,
    output logic [NSRC-1:0] stat,
    output logic [NSRC-1:0] ack_bits,
    output logic            bus_valid,
    output logic            bus_write,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_wdata,
    output logic            entry_done,
    output logic [AW-1:0]   new_pc,
    output logic [DW-1:0]   new_p,
    output logic [SW-1:0]   new_sp
);
    logic [NSRC-1:0] req_all;
    logic [NSRC-1:0] grant;
    logic            any;
    logic            take;
    logic            busy;
    logic [VW-1:0]   vec_pick;

    assign req_all  = {host_req, dma_req, tmr_req, nmi_req};
    assign take     = last_cycle & ~hold & ~busy & any;
    assign vec_pick = grant[SRC_NMI] ? nmi_vec : irq_vec;
    assign pending  = busy;

    intr_pick u_pick (
        .req     (req_all),
        .en      (irq_en),
        .blocked (ack_bits),
        .i_flag  (i_flag),
        .grant   (grant),
        .any     (any)
    );

    intr_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .grant   (grant),
        .ack_we  (ack_we),
        .ack_val (ack_val),
        .ack_q   (ack_bits),
        .stat_q  (stat)
    );

    intr_entry_fsm #(.AW(AW), .VW(VW), .SW(SW), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .vec_in    (vec_pick),
        .pc_in     (pc_in),
        .p_in      (p_in),
        .sp_in     (sp_in),
        .emu_in    (emu_mode),
        .bus_ready (bus_ready),
        .busy      (busy),
        .vec_q     (sel_vec),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .done      (entry_done),
        .new_pc    (new_pc),
        .new_p     (new_p),
        .new_sp    (new_sp)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wake <= 1'b0;
        else        wake <= take;
    end
endmodule

// File: rtl/intr_entry_chk.sv
module intr_entry_chk #(
    parameter int AW = 24,
    parameter int VW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          last_cycle,
    input logic          hold,
    input logic          i_flag,
    input logic          nmi_req,
    input logic [VW-1:0] nmi_vec,
    input logic          pending,
    input logic          wake,
    input logic [VW-1:0] sel_vec,
    input logic [3:0]    stat,
    input logic [3:0]    ack_bits,
    input logic          bus_valid,
    input logic          bus_ready,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          entry_done,
    input logic [DW-1:0] new_p
);
    a_r1_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && !last_cycle) |=> !pending);

    a_r10_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && hold) |=> !pending);

    a_r2_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && last_cycle && !hold && nmi_req && !ack_bits[0])
        |=> (pending && sel_vec == $past(nmi_vec) && stat[0]));

    a_r3_nmi_self_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && last_cycle && !hold && nmi_req && !ack_bits[0]) |=> ack_bits[0]);

    a_r4_i_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && last_cycle && i_flag && !(nmi_req && !ack_bits[0])) |=> !pending);

    a_r6_wake_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $rose(pending));

    a_r13_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready)
        |=> (bus_valid && $stable(bus_addr) && $stable(bus_wdata)));

    a_r9_flags_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> (new_p[2] && !new_p[3] && pending));
endmodule

bind intr_entry_ctrl intr_entry_chk #(.AW(AW), .VW(VW), .DW(DW)) u_chk (.*);

// File: tb/tb_intr_entry_ctrl.sv
module tb_intr_entry_ctrl;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, last_cycle, hold, i_flag, emu_mode;
    logic        nmi_req, tmr_req, dma_req, host_req;
    logic [2:0]  irq_en;
    logic        ack_we;
    logic [3:0]  ack_val;
    logic [15:0] nmi_vec, irq_vec;
    logic [23:0] pc_in;
    logic [7:0]  p_in;
    logic [15:0] sp_in;
    logic        bus_ready;
    logic        pending, wake, bus_valid, bus_write, entry_done;
    logic [15:0] sel_vec, new_sp;
    logic [3:0]  stat, ack_bits;
    logic [23:0] bus_addr, new_pc;
    logic [7:0]  bus_wdata, new_p;

    intr_entry_ctrl dut (.*);

    int total = 0;
    int bad   = 0;
    logic [3:0]  m_clr  = '0;
    logic [3:0]  m_stat = '0;
    logic [15:0] m_vec  = '0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int pick_m();
        if (hold) return -1;
        if (nmi_req && !m_clr[0]) return 0;
        if (i_flag) return -1;
        if (tmr_req && irq_en[0] && !m_clr[1]) return 1;
        if (dma_req && irq_en[1] && !m_clr[2]) return 2;
        if (host_req && irq_en[2] && !m_clr[3]) return 3;
        return -1;
    endfunction

    task automatic do_ack(logic [3:0] v);
        ack_we = 1'b1; ack_val = v;
        @(negedge clk);
        ack_we = 1'b0;
        m_stat = m_stat & ~v;
        m_clr  = v;
        chk("R12 stat after ack", stat, m_stat);
        chk("R12 ack_bits after ack", ack_bits, m_clr);
    endtask

    task automatic strobe(string req, bit slow);
        int s;
        int n;
        int idx;
        bit done_seen;
        bit prev_stall;
        logic [23:0] prev_addr;
        logic [23:0] ea [5];
        logic [7:0]  ed [5];
        logic [7:0]  pp;
        s = pick_m();
        last_cycle = 1'b1;
        @(negedge clk);
        last_cycle = 1'b0;
        if (s < 0) begin
            chk({req, " no accept"}, pending, 0);
            chk({req, " stat kept"}, stat, m_stat);
            chk({req, " ack kept"}, ack_bits, m_clr);
            return;
        end
        m_stat[s] = 1'b1;
        if (s == 0) m_clr[0] = 1'b1;
        m_vec = (s == 0) ? nmi_vec : irq_vec;
        chk({req, " pending"}, pending, 1);
        chk("R6 wake", wake, 1);
        chk({req, " vector"}, sel_vec, m_vec);
        chk({req, " stat"}, stat, m_stat);
        chk({req, " ack_bits"}, ack_bits, m_clr);
        // expected bus transfers
        n = 0;
        ea[n] = pc_in; ed[n] = 8'h00; n++;
        if (!emu_mode) begin ea[n] = {8'h00, sp_in - 16'(n-1)}; ed[n] = pc_in[23:16]; n++; end
        ea[n] = {8'h00, sp_in - 16'(n-1)}; ed[n] = pc_in[15:8]; n++;
        ea[n] = {8'h00, sp_in - 16'(n-1)}; ed[n] = pc_in[7:0]; n++;
        pp = emu_mode ? (p_in & 8'hEF) : p_in;
        ea[n] = {8'h00, sp_in - 16'(n-1)}; ed[n] = pp; n++;
        idx = 0; done_seen = 1'b0; prev_stall = 1'b0; prev_addr = '0;
        for (int c = 0; c < 60 && !done_seen; c++) begin
            if (prev_stall) chk("R13 addr held in stall", bus_addr, prev_addr);
            if (entry_done) begin
                done_seen = 1'b1;
                chk("R7 transfer count", idx, n);
                chk("R9 new_pc", new_pc, {8'h00, m_vec});
                chk("R9 new_p", new_p, (p_in | 8'h04) & 8'hF7);
                chk("R9 new_sp", new_sp, sp_in - 16'(n-1));
                bus_ready = 1'b0;
            end else if (bus_valid) begin
                bus_ready = slow ? ($urandom % 3 == 0) : 1'b1;
                if (bus_ready) begin
                    if (idx < n) begin
                        chk(emu_mode ? "R8 addr" : "R7 addr", bus_addr, ea[idx]);
                        chk(emu_mode ? "R8 data" : "R7 data", idx == 0 ? 8'h00 : bus_wdata, ed[idx]);
                        chk("R7 direction", bus_write, idx != 0);
                    end
                    idx++;
                end
                prev_stall = !bus_ready;
                prev_addr  = bus_addr;
            end else begin
                bus_ready = 1'b0;
                prev_stall = 1'b0;
            end
            @(negedge clk);
        end
        if (!done_seen) chk({req, " entry completed"}, 0, 1);
        chk({req, " back to idle"}, pending, 0);
        bus_ready = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; last_cycle = 0; hold = 0; i_flag = 1; emu_mode = 0;
        nmi_req = 0; tmr_req = 0; dma_req = 0; host_req = 0; irq_en = 0;
        ack_we = 0; ack_val = 0; nmi_vec = 16'h8F00; irq_vec = 16'h9A20;
        pc_in = 24'h12_3456; p_in = 8'h30; sp_in = 16'h01FF; bus_ready = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 pending", pending, 0);
        chk("R11 wake", wake, 0);
        chk("R11 stat", stat, 0);
        chk("R11 ack_bits", ack_bits, 0);
        chk("R11 sel_vec", sel_vec, 0);
        chk("R11 bus_valid", bus_valid, 0);

        // R1: requests present but no strobe
        nmi_req = 1; tmr_req = 1; irq_en = 3'b111; i_flag = 0;
        repeat (4) @(negedge clk);
        chk("R1 no strobe no entry", pending, 0);

        // R10: hold blocks
        hold = 1;
        strobe("R10 hold", 0);
        hold = 0;

        // R2/R3/R7/R9: NMI with I set, native
        i_flag = 1;
        strobe("R2 nmi over I", 0);
        // R3: NMI still requested, masked by its own bit
        strobe("R3 nmi self-masked", 0);

        // R4/R5: all sources, I clear -> timer
        i_flag = 0; dma_req = 1; host_req = 1;
        strobe("R4 timer first", 1);
        do_ack(4'b0011);
        strobe("R4 dma second", 0);
        do_ack(4'b0111);
        emu_mode = 1; p_in = 8'hFF;
        strobe("R8 host emu", 1);
        emu_mode = 0;
        do_ack(4'b1111);
        strobe("R4 all acked", 0);
        do_ack(4'b1110);
        irq_en = 3'b000;
        strobe("R4 enables off", 0);
        do_ack(4'b0000);
        strobe("R3 nmi after release", 0);

        // random mix
        for (int t = 0; t < 60; t++) begin
            nmi_req  = ($urandom % 4 == 0);
            tmr_req  = $urandom % 2; dma_req = $urandom % 2; host_req = $urandom % 2;
            irq_en   = 3'($urandom);
            i_flag   = $urandom % 2;
            emu_mode = $urandom % 2;
            hold     = ($urandom % 8 == 0);
            nmi_vec  = 16'($urandom); irq_vec = 16'($urandom);
            pc_in    = 24'($urandom); p_in = 8'($urandom); sp_in = 16'($urandom);
            if ($urandom % 3 == 0) do_ack(4'($urandom));
            strobe("R5 random", $urandom % 2);
            hold = 0;
            @(negedge clk);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule